// File: doc/BRIEF.md
# Block Store Completion Tracker

This block runs on one memory tile. For each of eight in-flight instruction block frames, it records which stores have arrived. The source of an arrival can be this tile's own store path or a message relayed over the multi-hop status network from a peer tile. Each frame keeps a 32-bit arrival vector indexed by the 5-bit load/store ID. The number of distinct IDs recorded is compared against the store count that the block header supplied when the frame was allocated. When the two meet, the block emits a one-cycle completion pulse for that frame.

The same arrival vector answers a combinational query from the deferred-load logic. Given a frame and a load ID, the query reports whether every store with a smaller ID has arrived. A store-ID mask, loaded when the frame is allocated, identifies which IDs are stores. The tracker also re-emits every local arrival onto the status network one cycle later, so that peer tiles see it well inside the three-cycle window.

Each frame is a small state machine with three states.

- `FR_IDLE`: the frame is unused. Arrivals are dropped and queries answer false.
- `FR_COLLECT`: arrivals are recorded.
- `FR_DONE`: the frame is complete and holds its vector.

The transitions are:

- *allocate*: `FR_IDLE` or `FR_DONE` to `FR_COLLECT`. This clears the vector and loads the count and the store mask.
- *complete*: `FR_COLLECT` to `FR_DONE`. This happens when the distinct arrival count reaches the expected count, and it fires the pulse.
- *release*: any state to `FR_IDLE`, on a free pulse.

Top module: `sct_tracker`

## Requirements
- R1: After reset, `done_pulse` is 0, `net_out_valid` is 0 and `qry_prior_done` is 0 for every frame.
- R2: After allocation with a count N greater than 0, `done_pulse[f]` goes high for exactly one cycle. It is high in the cycle after the clock edge that brings the number of distinct arrived IDs of frame f to N or more.
- R3: A frame allocated with an expected count of 0 pulses `done_pulse[f]` for one cycle, in the second cycle after the allocation edge.
- R4: An ID that is already recorded, or that arrives on both the local port and the network port in the same cycle, is counted once.
- R5: A local arrival and a network arrival in the same cycle are both recorded, whether they go to the same frame or to different frames.
- R6: `qry_prior_done` is 1 when frame `qry_frame` is in `FR_COLLECT` or `FR_DONE` and every ID i below `qry_lsid` that has bit i set in the store mask has arrived. It is 0 otherwise. Query ID 0 on a live frame reads 1. The query reflects arrivals up to the previous clock edge.
- R7: A free pulse returns the frame to `FR_IDLE`. Nothing pulses on the next cycle, and queries on the frame read 0. A free pulse wins over an allocation or an arrival to the same frame in the same cycle.
- R8: A local arrival appears on `net_out_*` in the next cycle with the same frame and ID. Network arrivals are never re-emitted.
- R9: Arrivals to a frame in `FR_IDLE` are dropped and do not count after a later allocation. Arrivals to a frame in `FR_DONE` cause no further pulse.
- R10: Frames are independent: arrivals to one frame never change the completion or the query of another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a frame |
| alloc_frame | input | 3 | Frame to allocate |
| alloc_count | input | 6 | Expected number of stores |
| alloc_store_mask | input | 32 | Bit i set means ID i is a store |
| free_valid | input | 1 | Release a frame |
| free_frame | input | 3 | Frame to release |
| loc_valid | input | 1 | Store arrived at this tile |
| loc_frame | input | 3 | Frame of the local store |
| loc_lsid | input | 5 | ID of the local store |
| net_in_valid | input | 1 | Arrival message from the status network |
| net_in_frame | input | 3 | Frame carried by the message |
| net_in_lsid | input | 5 | ID carried by the message |
| net_out_valid | output | 1 | Forwarded local arrival |
| net_out_frame | output | 3 | Frame of the forwarded arrival |
| net_out_lsid | output | 5 | ID of the forwarded arrival |
| done_pulse | output | 8 | One-cycle completion pulse per frame |
| qry_frame | input | 3 | Frame for the prior-store query |
| qry_lsid | input | 5 | Load ID for the query |
| qry_prior_done | output | 1 | All older stores of the frame have arrived |

## Verification
Two things can fall in the same cycle: a local arrival and a network arrival, and a free pulse together with an allocation or an arrival to the same frame. The bench drives both arrival ports in one cycle. It uses distinct IDs in the same frame, the same ID in the same frame, and IDs in two different frames. It judges the result from the exact cycle of `done_pulse` and from the prior-store query. The collisions with a free pulse are judged by the absence of a pulse afterwards and by the query reading 0.

// File: rtl/sct_pkg.sv
package sct_pkg;
    parameter int FRAMES = 8;
    parameter int IDS    = 32;
    localparam int FID_W = $clog2(FRAMES);
    localparam int ID_W  = $clog2(IDS);
    localparam int CNT_W = $clog2(IDS + 1);

    typedef enum logic [1:0] {
        FR_IDLE    = 2'd0,
        FR_COLLECT = 2'd1,
        FR_DONE    = 2'd2
    } frame_state_e;
endpackage

// File: rtl/sct_frame.sv
module sct_frame
    import sct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             free,
    input  logic [CNT_W-1:0] exp_in,
    input  logic [IDS-1:0]   smask_in,
    input  logic             hit_l,
    input  logic [ID_W-1:0]  id_l,
    input  logic             hit_n,
    input  logic [ID_W-1:0]  id_n,
    input  logic [ID_W-1:0]  q_id,
    output logic             done,
    output logic             prior
);
    frame_state_e     state_q, state_d;
    logic [IDS-1:0]   arr_q, arr_nxt, set_v, below;
    logic [IDS-1:0]   smask_q;
    logic [CNT_W-1:0] exp_q, seen;
    logic             done_q;

    function automatic logic [CNT_W-1:0] popcnt(input logic [IDS-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < IDS; i++) c = c + CNT_W'(v[i]);
        return c;
    endfunction

    always_comb begin
        set_v = '0;
        if (hit_l) set_v = set_v | (IDS'(1) << id_l);
        if (hit_n) set_v = set_v | (IDS'(1) << id_n);
        arr_nxt = arr_q | set_v;
        seen    = popcnt(arr_nxt);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (free) begin
            state_d = FR_IDLE;
        end else begin
            unique case (state_q)
                FR_IDLE:    if (alloc) state_d = FR_COLLECT;
                FR_COLLECT: if (seen >= exp_q) state_d = FR_DONE;
                FR_DONE:    if (alloc) state_d = FR_COLLECT;
                default:    state_d = FR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q   <= '0;
            smask_q <= '0;
            exp_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == FR_COLLECT) && (state_d == FR_DONE);
            if (free) begin
                arr_q <= '0;
            end else if (alloc && state_q != FR_COLLECT) begin
                arr_q   <= '0;
                smask_q <= smask_in;
                exp_q   <= exp_in;
            end else if (state_q == FR_COLLECT) begin
                arr_q <= arr_nxt;
            end
        end
    end

    assign below = (IDS'(1) << q_id) - IDS'(1);
    assign prior = (state_q != FR_IDLE) && ((smask_q & ~arr_q & below) == '0);
    assign done  = done_q;
endmodule

// File: rtl/sct_fwd.sv
module sct_fwd
    import sct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FID_W-1:0] in_frame,
    input  logic [ID_W-1:0]  in_lsid,
    output logic             out_valid,
    output logic [FID_W-1:0] out_frame,
    output logic [ID_W-1:0]  out_lsid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_frame <= '0;
            out_lsid  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_frame <= in_frame;
                out_lsid  <= in_lsid;
            end
        end
    end
endmodule

// File: rtl/sct_tracker.sv
module sct_tracker
    import sct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [FID_W-1:0]  alloc_frame,
    input  logic [CNT_W-1:0]  alloc_count,
    input  logic [IDS-1:0]    alloc_store_mask,
    input  logic              free_valid,
    input  logic [FID_W-1:0]  free_frame,
    input  logic              loc_valid,
    input  logic [FID_W-1:0]  loc_frame,
    input  logic [ID_W-1:0]   loc_lsid,
    input  logic              net_in_valid,
    input  logic [FID_W-1:0]  net_in_frame,
    input  logic [ID_W-1:0]   net_in_lsid,
    output logic              net_out_valid,
    output logic [FID_W-1:0]  net_out_frame,
    output logic [ID_W-1:0]   net_out_lsid,
    output logic [FRAMES-1:0] done_pulse,
    input  logic [FID_W-1:0]  qry_frame,
    input  logic [ID_W-1:0]   qry_lsid,
    output logic              qry_prior_done
);
    logic [FRAMES-1:0] prior_v;

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        sct_frame u_frame (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_valid && alloc_frame == FID_W'(f)),
            .free     (free_valid && free_frame == FID_W'(f)),
            .exp_in   (alloc_count),
            .smask_in (alloc_store_mask),
            .hit_l    (loc_valid && loc_frame == FID_W'(f)),
            .id_l     (loc_lsid),
            .hit_n    (net_in_valid && net_in_frame == FID_W'(f)),
            .id_n     (net_in_lsid),
            .q_id     (qry_lsid),
            .done     (done_pulse[f]),
            .prior    (prior_v[f])
        );
    end

    sct_fwd u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (loc_valid),
        .in_frame  (loc_frame),
        .in_lsid   (loc_lsid),
        .out_valid (net_out_valid),
        .out_frame (net_out_frame),
        .out_lsid  (net_out_lsid)
    );

    assign qry_prior_done = prior_v[qry_frame];
endmodule

// File: rtl/sct_tracker_chk.sv
module sct_tracker_chk
    import sct_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              free_valid,
    input logic [FID_W-1:0]  free_frame,
    input logic              loc_valid,
    input logic [FID_W-1:0]  loc_frame,
    input logic [ID_W-1:0]   loc_lsid,
    input logic              net_out_valid,
    input logic [FID_W-1:0]  net_out_frame,
    input logic [ID_W-1:0]   net_out_lsid,
    input logic [FRAMES-1:0] done_pulse,
    input logic [FID_W-1:0]  qry_frame,
    input logic              qry_prior_done
);
    // R8
    fwd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |=> net_out_valid);

    // R8
    fwd_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |=> (net_out_frame == $past(loc_frame)) && (net_out_lsid == $past(loc_lsid)));

    // R8
    fwd_only_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_valid |=> !net_out_valid);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse != '0) |=> ((done_pulse & $past(done_pulse)) == '0));

    // R7
    free_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |=> !done_pulse[$past(free_frame)]);

    // R7
    free_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |=> (qry_frame != $past(free_frame)) || !qry_prior_done);
endmodule

bind sct_tracker sct_tracker_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .free_valid     (free_valid),
    .free_frame     (free_frame),
    .loc_valid      (loc_valid),
    .loc_frame      (loc_frame),
    .loc_lsid       (loc_lsid),
    .net_out_valid  (net_out_valid),
    .net_out_frame  (net_out_frame),
    .net_out_lsid   (net_out_lsid),
    .done_pulse     (done_pulse),
    .qry_frame      (qry_frame),
    .qry_prior_done (qry_prior_done)
);

// File: tb/sct_tracker_bench.sv
`timescale 1ns/1ps
module sct_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [2:0]  alloc_frame = '0;
    logic [5:0]  alloc_count = '0;
    logic [31:0] alloc_store_mask = '0;
    logic        free_valid = 1'b0;
    logic [2:0]  free_frame = '0;
    logic        loc_valid = 1'b0;
    logic [2:0]  loc_frame = '0;
    logic [4:0]  loc_lsid = '0;
    logic        net_in_valid = 1'b0;
    logic [2:0]  net_in_frame = '0;
    logic [4:0]  net_in_lsid = '0;
    logic        net_out_valid;
    logic [2:0]  net_out_frame;
    logic [4:0]  net_out_lsid;
    logic [7:0]  done_pulse;
    logic [2:0]  qry_frame = '0;
    logic [4:0]  qry_lsid = '0;
    logic        qry_prior_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sct_tracker u_sct_tracker (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_frame(alloc_frame),
        .alloc_count(alloc_count), .alloc_store_mask(alloc_store_mask),
        .free_valid(free_valid), .free_frame(free_frame),
        .loc_valid(loc_valid), .loc_frame(loc_frame), .loc_lsid(loc_lsid),
        .net_in_valid(net_in_valid), .net_in_frame(net_in_frame), .net_in_lsid(net_in_lsid),
        .net_out_valid(net_out_valid), .net_out_frame(net_out_frame), .net_out_lsid(net_out_lsid),
        .done_pulse(done_pulse),
        .qry_frame(qry_frame), .qry_lsid(qry_lsid), .qry_prior_done(qry_prior_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock edge, then settle at the falling edge with all strobes cleared
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 0; free_valid = 0; loc_valid = 0; net_in_valid = 0;
    endtask

    task automatic do_alloc(input logic [2:0] f, input logic [5:0] n, input logic [31:0] m);
        alloc_valid = 1; alloc_frame = f; alloc_count = n; alloc_store_mask = m;
    endtask

    task automatic do_loc(input logic [2:0] f, input logic [4:0] id);
        loc_valid = 1; loc_frame = f; loc_lsid = id;
    endtask

    task automatic do_net(input logic [2:0] f, input logic [4:0] id);
        net_in_valid = 1; net_in_frame = f; net_in_lsid = id;
    endtask

    function automatic logic query(input logic [2:0] f, input logic [4:0] id);
        return 1'b0;
    endfunction

    task automatic ask(input string req, input logic [2:0] f, input logic [4:0] id, input logic exp);
        qry_frame = f; qry_lsid = id;
        #0.5;
        chk(req, 32'(qry_prior_done), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R1 done", 32'(done_pulse), 0);
        chk("R1 net_out_valid", 32'(net_out_valid), 0);
        ask("R1 query", 3'd0, 5'd0, 1'b0);
    endtask

    task automatic t_basic();
        do_alloc(3'd2, 6'd3, 32'h0000_0092);  // stores at IDs 1,4,7
        tick();
        ask("R6 live id0", 3'd2, 5'd0, 1'b1);
        do_loc(3'd2, 5'd4);
        tick();
        chk("R8 fwd valid", 32'(net_out_valid), 1);
        chk("R8 fwd frame", 32'(net_out_frame), 2);
        chk("R8 fwd id", 32'(net_out_lsid), 4);
        chk("R2 early", 32'(done_pulse), 0);
        ask("R6 id1 missing", 3'd2, 5'd5, 1'b0);
        ask("R6 below id1", 3'd2, 5'd1, 1'b1);
        do_net(3'd2, 5'd1);
        tick();
        chk("R8 net not fwd", 32'(net_out_valid), 0);
        ask("R6 ids1,4 in", 3'd2, 5'd5, 1'b1);
        ask("R6 id7 missing", 3'd2, 5'd8, 1'b0);
        do_net(3'd2, 5'd7);
        tick();
        chk("R2 pulse", 32'(done_pulse), 32'h04);
        ask("R6 all in", 3'd2, 5'd31, 1'b1);
        tick();
        chk("R2 single cycle", 32'(done_pulse), 0);
    endtask

    task automatic t_zero();
        do_alloc(3'd5, 6'd0, 32'h0);
        tick();
        chk("R3 not yet", 32'(done_pulse), 0);
        tick();
        chk("R3 pulse", 32'(done_pulse), 32'h20);
        tick();
        chk("R3 single", 32'(done_pulse), 0);
    endtask

    task automatic t_dup();
        do_alloc(3'd1, 6'd2, 32'h0000_0208);
        tick();
        do_loc(3'd1, 5'd3); do_net(3'd1, 5'd3);
        tick();
        chk("R4 same id both ports", 32'(done_pulse), 0);
        do_loc(3'd1, 5'd3);
        tick();
        chk("R4 repeat id", 32'(done_pulse), 0);
        do_net(3'd1, 5'd9);
        tick();
        chk("R4 second distinct", 32'(done_pulse), 32'h02);
        tick();
    endtask

    task automatic t_same_cycle();
        do_alloc(3'd3, 6'd2, 32'h0000_0041);
        tick();
        do_loc(3'd3, 5'd0); do_net(3'd3, 5'd6);
        tick();
        chk("R5 both recorded", 32'(done_pulse), 32'h08);
        chk("R5 local fwd", 32'(net_out_lsid), 0);
        tick();
    endtask

    task automatic t_free();
        do_alloc(3'd4, 6'd1, 32'h1);
        tick();
        free_valid = 1; free_frame = 3'd4;
        do_alloc(3'd4, 6'd1, 32'h1);
        tick();
        ask("R7 free beats alloc", 3'd4, 5'd0, 1'b0);
        do_loc(3'd4, 5'd0);
        tick();
        chk("R7 idle arrival", 32'(done_pulse), 0);
        tick();
        chk("R7 idle arrival later", 32'(done_pulse), 0);
        do_alloc(3'd4, 6'd1, 32'h1);
        tick();
        ask("R7 live again", 3'd4, 5'd3, 1'b0);
        free_valid = 1; free_frame = 3'd4;
        do_loc(3'd4, 5'd0);
        tick();
        chk("R7 free beats arrival", 32'(done_pulse), 0);
        ask("R7 query after free", 3'd4, 5'd3, 1'b0);
        tick();
        chk("R7 no late pulse", 32'(done_pulse), 0);
    endtask

    task automatic t_ignored();
        do_loc(3'd2, 5'd20);  // frame 2 is done
        tick();
        tick();
        chk("R9 done frame no pulse", 32'(done_pulse), 0);
        do_net(3'd6, 5'd2);   // frame 6 idle
        tick();
        do_alloc(3'd6, 6'd1, 32'h4);
        tick();
        tick();
        chk("R9 idle arrival dropped", 32'(done_pulse), 0);
        ask("R9 id2 not recorded", 3'd6, 5'd3, 1'b0);
        do_loc(3'd6, 5'd2);
        tick();
        chk("R9 counted after alloc", 32'(done_pulse), 32'h40);
        tick();
    endtask

    task automatic t_indep();
        do_alloc(3'd0, 6'd1, 32'h4);
        tick();
        do_alloc(3'd7, 6'd2, 32'h4);
        tick();
        do_loc(3'd0, 5'd2); do_net(3'd7, 5'd2);
        tick();
        chk("R10 only frame0", 32'(done_pulse), 32'h01);
        ask("R10 frame7 query", 3'd7, 5'd5, 1'b1);
        do_net(3'd7, 5'd9);
        tick();
        chk("R10 frame7 alone", 32'(done_pulse), 32'h80);
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_zero();
        t_dup();
        t_same_cycle();
        t_free();
        t_ignored();
        t_indep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule